// File: doc/BRIEF.md
# I2C Register-File Slave

This block puts a small byte-wide register space on a two-wire serial bus as a target device. It watches SCL and SDA through synchronisers clocked by a fast system clock. It recognises START, repeated START and STOP conditions and answers only to its own 7-bit device address. Write transfers first set an internal word pointer and then store bytes at that pointer. Read transfers return the byte at the pointer and advance it each time the master acknowledges.

The register space holds eight bytes in its default build. Seven of them are general timekeeping bytes. The top index holds a control byte, which is also presented on a port so that neighbouring logic can use it. A read-in-progress flag tells a neighbouring timekeeper when a read burst is under way, so that it can hold back updates. A supply-good input forces the block idle: while it is low, the pointer is cleared and all bus activity is ignored.

SDA is driven open-drain: `sda_oe` high means the block pulls the line low. Otherwise it releases the line.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The block acknowledges only the address byte 1101000 followed by the R/W bit, i.e. D0h for a write or D1h for a read. For any other address it drives no ACK and changes no register.
- R2: The block changes `sda_oe` only while SCL is low. Power-fail is the only exception.
- R3: In a write transfer, the first byte after the address loads the word pointer from its low bits (bits 2:0 by default). Each further byte is stored at the pointer, and the pointer then advances by one.
- R4: In a read transfer, the pointer advances only when the master acknowledges a byte. A master NACK ends the read, and the block keeps SDA released.
- R5: A read transfer with no pointer write before it starts at the pointer value left by the previous access.
- R6: A repeated START followed by the address with R/W = 1 switches the block to transmitting, with the first data bit driven after the ACK.
- R7: The pointer wraps from the last index (7) back to 0, for both writes and reads.
- R8: A START or STOP condition at any point resets the bit counter. A START in the middle of a byte restarts the address phase.
- R9: While `pwr_good` is low, any transfer is abandoned, SDA is released, the pointer is 0 and the bus is ignored. In particular, no ACK is given and no write takes effect.
- R10: After reset, the control byte (index 7) reads 80h: bit 7 (output level) is 1 and bit 6 (frequency test) is 0. All other registers read 00h.
- R11: `rd_active` is high from the first transmitted data byte until a master NACK, STOP, START or power-fail. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_good | input | 1 | Supply-good indication; low aborts and ignores the bus |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| rd_active | output | 1 | High while a read burst is in progress |
| ctrl_byte | output | 8 | Current contents of the control register |

## Verification
The bench builds the block with its defaults: two synchroniser stages, eight registers, device address 68h and the control register at index 7. With only eight entries, a three-byte burst starting at index 6 crosses the wrap, so the pointer rollover is exercised in both write and read directions. The three-cycle input latency sits well inside the bench's five-cycle bus quarter period, so ACK and data timing can be checked on exact bus phases. The sequence also reaches a current-address read whose result depends on the preceding NACK not advancing the pointer, a START after four bits, and a power-fail in the middle of a byte followed by a full transfer while the supply is low.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK
   } bus_state_t;

   // synchronised line levels and single-cycle bus events
   typedef struct packed {
      logic scl;
      logic sda;
      logic scl_rise;
      logic scl_fall;
      logic start;
      logic stop;
   } bus_ev_t;

endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output i2cr_pkg::bus_ev_t ev
);
   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_d;
   logic              sda_d;

   if (STAGES < 1) begin : g_bad_stages
      $error("i2cr_sync: STAGES must be at least 1");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               scl_ff[0] <= 1'b1;
               sda_ff[0] <= 1'b1;
            end else begin
               scl_ff[0] <= scl_i;
               sda_ff[0] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               scl_ff[g] <= 1'b1;
               sda_ff[g] <= 1'b1;
            end else begin
               scl_ff[g] <= scl_ff[g-1];
               sda_ff[g] <= sda_ff[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_ff[STAGES-1];
         sda_d <= sda_ff[STAGES-1];
      end
   end

   always_comb begin
      ev.scl      = scl_ff[STAGES-1];
      ev.sda      = sda_ff[STAGES-1];
      ev.scl_rise = ev.scl & ~scl_d;
      ev.scl_fall = ~ev.scl & scl_d;
      ev.start    = ev.scl & scl_d & sda_d & ~ev.sda;
      ev.stop     = ev.scl & scl_d & ~sda_d & ev.sda;
   end
endmodule

// File: rtl/i2cr_regs.sv
module i2cr_regs #(
   parameter int               NUM_REGS = 8,
   parameter int               CTRL_IDX = NUM_REGS - 1,
   parameter logic [7:0]       CTRL_RST = 8'h80,
   localparam int              PTR_W    = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PTR_W-1:0] wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [PTR_W-1:0] rd_addr,
   output logic [7:0]       rd_data,
   output logic [7:0]       ctrl_q
);
   logic [NUM_REGS-1:0][7:0] store;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [7:0] RST_VAL = (g == CTRL_IDX) ? CTRL_RST : 8'h00;
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= RST_VAL;
         else if (wr_en && (wr_addr == PTR_W'(g)))
            q <= wr_data;
      end
      assign store[g] = q;
   end

   assign rd_data = store[rd_addr];
   assign ctrl_q  = store[CTRL_IDX];
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'b1101000,
   parameter int         NUM_REGS    = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] CTRL_RST    = 8'h80
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_good,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   output logic       rd_active,
   output logic [7:0] ctrl_byte
);
   import i2cr_pkg::*;

   localparam int              PTR_W   = $clog2(NUM_REGS);
   localparam int              CTRL_IX = NUM_REGS - 1;
   localparam logic [PTR_W-1:0] PTR_ONE = 1;

   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("i2c_regfile_slave: NUM_REGS must be a power of two >= 2");
   end
   if (NUM_REGS > 256) begin : g_bad_span
      $error("i2c_regfile_slave: NUM_REGS exceeds one pointer byte");
   end

   bus_ev_t          ev;
   bus_state_t       state_q;
   logic [3:0]       bit_cnt_q;
   logic [7:0]       sh_q;
   logic [7:0]       tx_q;
   logic [PTR_W-1:0] ptr_q;
   logic             rw_q;
   logic             ptr_load_q;
   logic             mack_q;
   logic             wr_en;
   logic [7:0]       rd_data;
   logic             scl_now;
   logic             byte_end;

   i2cr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev    (ev)
   );

   assign scl_now  = ev.scl;
   assign byte_end = ev.scl_fall && (bit_cnt_q == 4'd8);
   assign wr_en    = pwr_good && !ev.start && !ev.stop && (state_q == ST_WR)
                     && byte_end && !ptr_load_q;

   i2cr_regs #(
      .NUM_REGS (NUM_REGS),
      .CTRL_IDX (CTRL_IX),
      .CTRL_RST (CTRL_RST)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (ptr_q),
      .wr_data (sh_q),
      .rd_addr (ptr_q),
      .rd_data (rd_data),
      .ctrl_q  (ctrl_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         bit_cnt_q  <= 4'd0;
         sh_q       <= 8'h00;
         tx_q       <= 8'h00;
         ptr_q      <= '0;
         rw_q       <= 1'b0;
         ptr_load_q <= 1'b0;
         mack_q     <= 1'b0;
         sda_oe     <= 1'b0;
         rd_active  <= 1'b0;
      end else if (!pwr_good) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= 4'd0;
         ptr_q     <= '0;
         sda_oe    <= 1'b0;
         rd_active <= 1'b0;
      end else if (ev.start) begin
         state_q    <= ST_ADDR;
         bit_cnt_q  <= 4'd0;
         ptr_load_q <= 1'b1;
         sda_oe     <= 1'b0;
         rd_active  <= 1'b0;
      end else if (ev.stop) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= 4'd0;
         sda_oe    <= 1'b0;
         rd_active <= 1'b0;
      end else begin
         unique case (state_q)
            ST_ADDR: begin
               if (ev.scl_rise) begin
                  sh_q      <= {sh_q[6:0], ev.sda};
                  bit_cnt_q <= bit_cnt_q + 4'd1;
               end else if (byte_end) begin
                  if (sh_q[7:1] == DEV_ADDR) begin
                     rw_q    <= sh_q[0];
                     sda_oe  <= 1'b1;
                     state_q <= ST_ADDR_ACK;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (ev.scl_fall) begin
                  bit_cnt_q <= 4'd0;
                  if (rw_q) begin
                     tx_q      <= rd_data;
                     sda_oe    <= ~rd_data[7];
                     rd_active <= 1'b1;
                     state_q   <= ST_RD;
                  end else begin
                     sda_oe  <= 1'b0;
                     state_q <= ST_WR;
                  end
               end
            end
            ST_WR: begin
               if (ev.scl_rise) begin
                  sh_q      <= {sh_q[6:0], ev.sda};
                  bit_cnt_q <= bit_cnt_q + 4'd1;
               end else if (byte_end) begin
                  sda_oe  <= 1'b1;
                  state_q <= ST_WR_ACK;
                  if (ptr_load_q) begin
                     ptr_q      <= sh_q[PTR_W-1:0];
                     ptr_load_q <= 1'b0;
                  end else begin
                     ptr_q <= ptr_q + PTR_ONE;
                  end
               end
            end
            ST_WR_ACK: begin
               if (ev.scl_fall) begin
                  sda_oe    <= 1'b0;
                  bit_cnt_q <= 4'd0;
                  state_q   <= ST_WR;
               end
            end
            ST_RD: begin
               if (ev.scl_rise) begin
                  bit_cnt_q <= bit_cnt_q + 4'd1;
               end else if (ev.scl_fall) begin
                  if (bit_cnt_q == 4'd8) begin
                     sda_oe  <= 1'b0;
                     state_q <= ST_RD_ACK;
                  end else begin
                     tx_q   <= {tx_q[6:0], 1'b0};
                     sda_oe <= ~tx_q[6];
                  end
               end
            end
            ST_RD_ACK: begin
               if (ev.scl_rise) begin
                  mack_q <= ~ev.sda;
                  if (!ev.sda)
                     ptr_q <= ptr_q + PTR_ONE;
               end else if (ev.scl_fall) begin
                  bit_cnt_q <= 4'd0;
                  if (mack_q) begin
                     tx_q    <= rd_data;
                     sda_oe  <= ~rd_data[7];
                     state_q <= ST_RD;
                  end else begin
                     rd_active <= 1'b0;
                     state_q   <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker #(
   parameter int PTR_W = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 pwr_good,
   input logic                 sda_oe,
   input logic                 rd_active,
   input logic                 scl_s,
   input logic [PTR_W-1:0]     ptr,
   input i2cr_pkg::bus_state_t state
);
   import i2cr_pkg::*;

   // R9: one cycle of low supply leaves the bus released and pointer at 0
   p_pwr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> (!sda_oe && !rd_active && ptr == '0));

   // R2: the pull-down engages only while the synchronised SCL is low
   p_drive_low_scl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   // R4: inside one read burst the pointer holds or steps by one
   p_read_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_active && $past(rd_active)) |-> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1));

   // R11: the read flag lives only in the transmit states
   p_rdflag_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_active |-> (state == ST_RD || state == ST_RD_ACK));

   // R1: SDA is pulled only for an ACK or while transmitting
   p_oe_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (state == ST_ADDR_ACK || state == ST_WR_ACK || state == ST_RD));
endmodule

bind i2c_regfile_slave i2cr_checker #(.PTR_W(PTR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_good  (pwr_good),
   .sda_oe    (sda_oe),
   .rd_active (rd_active),
   .scl_s     (scl_now),
   .ptr       (ptr_q),
   .state     (state_q)
);

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;
   localparam int Q = 5;   // clocks per quarter of an SCL period

   logic       clk = 1'b0;
   logic       rst_n, pwr_good, scl_m, sda_m;
   logic       sda_oe, rd_active, sda_bus;
   logic [7:0] ctrl_byte;
   int         n_chk = 0, n_fail = 0, r2_viol = 0;
   bit         done = 1'b0, ack, oe_prev = 1'b0;
   logic [7:0] exp_q[$];
   logic [7:0] got_q[$];
   string      req_q[$];

   always #5 clk = ~clk;
   assign sda_bus = sda_m & ~sda_oe;

   i2c_regfile_slave u_dut (
      .clk (clk), .rst_n (rst_n), .pwr_good (pwr_good),
      .scl_i (scl_m), .sda_i (sda_bus),
      .sda_oe (sda_oe), .rd_active (rd_active), .ctrl_byte (ctrl_byte)
   );

   task automatic check(string req, int act, int exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: pairs observed read bytes with expectations
   always @(negedge clk) begin
      if (got_q.size() > 0 && exp_q.size() > 0)
         check(req_q.pop_front(), int'(got_q.pop_front()), int'(exp_q.pop_front()), "read byte");
   end

   // R2 monitor: pull-down must not move while SCL is high (supply good)
   always @(posedge clk) begin
      if (rst_n && pwr_good && scl_m && (sda_oe != oe_prev)) r2_viol++;
      oe_prev <= sda_oe;
   end

   task automatic qt(); repeat (Q) @(negedge clk); endtask
   task automatic b_start(); sda_m = 1; scl_m = 1; qt(); sda_m = 0; qt(); scl_m = 0; qt(); endtask
   task automatic b_rstart(); sda_m = 1; qt(); scl_m = 1; qt(); sda_m = 0; qt(); scl_m = 0; qt(); endtask
   task automatic b_stop(); sda_m = 0; qt(); scl_m = 1; qt(); sda_m = 1; qt(); endtask
   task automatic wbit(input bit b); sda_m = b; qt(); scl_m = 1; qt(); qt(); scl_m = 0; qt(); endtask
   task automatic rbit(output bit b); sda_m = 1; qt(); scl_m = 1; qt(); b = sda_bus; qt(); scl_m = 0; qt(); endtask

   task automatic send(input logic [7:0] d, output bit a);
      bit s;
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(s);
      a = ~s;
   endtask

   task automatic recv(input bit give_ack);
      logic [7:0] d;
      bit s;
      for (int i = 7; i >= 0; i--) begin rbit(s); d[i] = s; end
      got_q.push_back(d);
      wbit(~give_ack);
   endtask

   task automatic expect_byte(input logic [7:0] v, input string req);
      exp_q.push_back(v);
      req_q.push_back(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; pwr_good = 1; scl_m = 1; sda_m = 1;
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (4) @(negedge clk);
      check("R10", ctrl_byte, 8'h80, "control reset value");
      check("R10", sda_oe, 0, "sda released after reset");
      check("R11", rd_active, 0, "read flag after reset");

      // R1: foreign address ignored, its data must not land in reg 5
      b_start(); send(8'hA0, ack); check("R1", ack, 0, "foreign address ack");
      send(8'h05, ack); send(8'h55, ack); b_stop();

      // R3: pointer write then burst write
      b_start(); send(8'hD0, ack); check("R1", ack, 1, "own address ack");
      send(8'h02, ack); check("R3", ack, 1, "pointer byte ack");
      send(8'h11, ack); send(8'h22, ack); send(8'h33, ack);
      check("R3", ack, 1, "data byte ack"); b_stop();

      // R6: random read through repeated START
      b_start(); send(8'hD0, ack); send(8'h02, ack); b_rstart();
      send(8'hD1, ack); check("R6", ack, 1, "read address ack");
      expect_byte(8'h11, "R6"); expect_byte(8'h22, "R3"); expect_byte(8'h33, "R3");
      recv(1); check("R11", rd_active, 1, "read flag during burst");
      recv(1); recv(0);
      check("R4", sda_oe, 0, "released after NACK");
      check("R11", rd_active, 0, "read flag after NACK");
      b_stop();

      // R5/R4: current-address read; the NACK must not have advanced (ptr 4)
      b_start(); send(8'hD1, ack); expect_byte(8'h33, "R5"); recv(0); b_stop();

      // R1: reg 5 untouched by the foreign transfer
      b_start(); send(8'hD0, ack); send(8'h05, ack); b_rstart(); send(8'hD1, ack);
      expect_byte(8'h00, "R1"); recv(0); b_stop();

      // R7: write across the wrap
      b_start(); send(8'hD0, ack); send(8'h06, ack);
      send(8'hA6, ack); send(8'hA7, ack); send(8'hA0, ack); b_stop();
      check("R7", ctrl_byte, 8'hA7, "control byte via wrap burst");
      b_start(); send(8'hD0, ack); send(8'h07, ack); b_rstart(); send(8'hD1, ack);
      expect_byte(8'hA7, "R7"); expect_byte(8'hA0, "R7"); recv(1); recv(0); b_stop();

      // R8: START after four bits restarts the address phase
      b_start(); wbit(1); wbit(0); wbit(1); wbit(1); b_rstart();
      send(8'hD0, ack); check("R8", ack, 1, "address after mid-byte START");
      send(8'h01, ack); send(8'h5A, ack); b_stop();
      b_start(); send(8'hD0, ack); send(8'h01, ack); b_rstart(); send(8'hD1, ack);
      expect_byte(8'h5A, "R8"); recv(0); b_stop();

      // R9: power-fail mid-byte, then a full transfer while supply is low
      b_start(); send(8'hD0, ack); send(8'h03, ack); wbit(1); wbit(1);
      pwr_good = 0; repeat (3) @(negedge clk);
      check("R9", sda_oe, 0, "released on power-fail");
      wbit(1); b_stop();
      b_start(); send(8'hD0, ack); check("R9", ack, 0, "no ack while supply low");
      send(8'h00, ack); send(8'hEE, ack); b_stop();
      pwr_good = 1; repeat (4) @(negedge clk);
      b_start(); send(8'hD1, ack); expect_byte(8'hA0, "R9"); recv(0); b_stop();

      repeat (4) @(negedge clk);
      check("R4", exp_q.size(), 0, "all expected bytes observed");
      check("R2", r2_viol, 0, "drive changes while SCL high");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule